// File: doc/BRIEF.md
# Audio Frame Sequencer Controller

This block paces the slow modulation units of a multi-channel sound generator. It counts CPU clock cycles and fires single-cycle quarter-frame and half-frame strobes. Envelope units use the quarter-frame strobe. Length and sweep units use the half-frame strobe. It can also raise a frame interrupt-pending flag at the end of each frame.

The block has two step patterns. The four-step pattern has four strobe points per frame and can request an interrupt. The five-step pattern has five points, the last of which is silent, and it never requests an interrupt. Software chooses the pattern and the interrupt inhibit by writing a control byte. Only the two upper bits of that byte reach this block. Each write restarts the frame count. The restart point depends on whether the write lands on an even or an odd CPU cycle. A read of the sound status register pulses a clear input that drops the pending flag.

The step points are parameters. By default they sit near 7457, 14913, 22371, 29829 and 37281 cycles.

Top module: `frame_seq_ctrl`

## Requirements
- R1: After reset the block is in four-step mode with the interrupt disabled, the flag low, both strobes low and the count at zero. The first quarter strobe is seen STEP1 cycles after the first clock edge out of reset.
- R2: In four-step mode, steps 1 and 3 give a quarter strobe alone. Steps 2 and 4 give both strobes. The count wraps after step 4, so the frame lasts STEP4+1 cycles.
- R3: In four-step mode, step 4 sets the pending flag when the interrupt is enabled, and leaves it clear when disabled.
- R4: In five-step mode, steps 1 and 3 give both strobes and steps 2 and 4 give a quarter strobe alone. Step 5 gives nothing. The frame lasts STEP5+1 cycles.
- R5: In five-step mode the pending flag is never set.
- R6: On a write, `ctl_mode_bit` (control byte bit 7) selects the mode: 0 is four-step and 1 is five-step. `ctl_irq_inhibit_bit` (bit 6) set to 1 disables the interrupt, and 0 enables it.
- R7: A write with bit 6 set clears the pending flag on the next cycle. A write with bit 6 clear leaves the flag unchanged.
- R8: A write selecting five-step gives one quarter strobe and one half strobe together on the next cycle. A write selecting four-step gives no strobe.
- R9: Cycle parity counts from the first edge out of reset, which is even. A write on an even cycle restarts the count so that step 1 comes STEP1 cycles later. On an odd cycle it comes STEP1-1 cycles later.
- R10: A `stat_rd` pulse clears the pending flag on the next cycle. If a flag-setting step 4 falls in the same cycle, the set wins.
- R11: Strobes and the flag are registered. Each strobe is high for exactly one cycle per step point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_mode_bit | input | 1 | Written control bit 7: 1 selects five-step |
| ctl_irq_inhibit_bit | input | 1 | Written control bit 6: 1 disables interrupt |
| stat_rd | input | 1 | Status read pulse, clears the pending flag |
| qtr_stb | output | 1 | Quarter-frame strobe |
| half_stb | output | 1 | Half-frame strobe |
| irq_pend | output | 1 | Frame interrupt pending |

## Verification
Every result is one register deep. An input sampled on edge k shows on the outputs just after edge k. This holds for the strobes at a step point, the strobes fired by a write, and the set or clear of the flag. The bench drives inputs at the falling edge and advances one rising edge. It then updates a requirement-level model of count, parity, mode and flag at that edge, and compares all three outputs at the next falling edge. Every cycle is checked, so an early or late strobe shows up in the very cycle it goes wrong. The step points are made small so that several frames of each mode fit in a short run.

// File: rtl/frame_seq_pkg.sv
// Shared types for the frame sequencer controller.
package frame_seq_pkg;

    typedef enum logic {
        SEQ_FOUR = 1'b0,
        SEQ_FIVE = 1'b1
    } seq_mode_e;

    // Strobe request produced by the step decoder for one cycle
    typedef struct packed {
        logic qtr;
        logic half;
        logic irq_step;
    } step_evt_t;

    localparam int unsigned NSTEP = 5;

endpackage

// File: rtl/fseq_ctl.sv
// Control state: holds mode and interrupt enable from the last write and
// tracks CPU-cycle parity. Assumes parity 0 (even) on the first edge out
// of reset.
module fseq_ctl
    import frame_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic      mode_bit,
    input  logic      inhibit_bit,
    output seq_mode_e mode,
    output logic      irq_en,
    output logic      odd
);

    // Capture mode and interrupt enable on each control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= SEQ_FOUR;
            irq_en <= 1'b0;
        end else if (wr) begin
            mode   <= seq_mode_e'(mode_bit);
            irq_en <= ~inhibit_bit;
        end
    end

    // Toggle cycle parity every clock
    always_ff @(posedge clk) begin
        if (!rst_n) odd <= 1'b0;
        else        odd <= ~odd;
    end

    // R6
    ctl_write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mode == seq_mode_e'($past(mode_bit))) && (irq_en == !$past(inhibit_bit)));

endmodule

// File: rtl/fseq_timer.sv
// Cycle counter with per-step match flags. It wraps after the last step of
// the active mode and restarts at 1 or 2 on a control write, by parity.
// Assumes the step points rise strictly.
module fseq_timer
    import frame_seq_pkg::*;
#(
    parameter int unsigned STEP_AT [NSTEP] = '{7457, 14913, 22371, 29829, 37281},
    localparam int unsigned CW = $clog2(STEP_AT[NSTEP-1] + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             odd,
    input  seq_mode_e        mode,
    output logic [NSTEP-1:0] hit
);

    logic [CW-1:0] cnt;
    logic          wrap;

    // One match flag per step point
    for (genvar k = 0; k < NSTEP; k++) begin : g_hit
        assign hit[k] = (cnt == CW'(STEP_AT[k]));
    end

    // Last step of the active pattern ends the frame
    always_comb begin
        wrap = (mode == SEQ_FOUR) ? hit[3] : hit[4];
    end

    // Advance, wrap or realign the counter
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wr)   cnt <= odd ? CW'(2) : CW'(1);
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end

    // R2 R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(STEP_AT[NSTEP-1]));

    // R9
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt == ($past(odd) ? CW'(2) : CW'(1))));

endmodule

// File: rtl/fseq_decode.sv
// Maps step matches and mode to strobe requests. A write overrides the
// step decode: five-step writes request both strobes at once.
module fseq_decode
    import frame_seq_pkg::*;
(
    input  logic [NSTEP-1:0] hit,
    input  seq_mode_e        mode,
    input  logic             wr,
    input  logic             wr_mode_bit,
    output step_evt_t        evt
);

    // Select the strobe mix for the current step
    always_comb begin
        evt = '0;
        if (wr) begin
            evt.qtr  = wr_mode_bit;
            evt.half = wr_mode_bit;
        end else if (mode == SEQ_FOUR) begin
            evt.qtr      = |hit[3:0];
            evt.half     = hit[1] | hit[3];
            evt.irq_step = hit[3];
        end else begin
            evt.qtr  = |hit[3:0];
            evt.half = hit[0] | hit[2];
        end
    end

endmodule

// File: rtl/fseq_irq.sv
// Frame interrupt pending flag. A write with inhibit clears it first,
// then a step-4 event (if enabled) sets it, then a status read clears it.
module fseq_irq
    import frame_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      set_req,
    input  logic      irq_en,
    input  seq_mode_e mode,
    input  logic      wr,
    input  logic      inhibit_bit,
    input  logic      rd_clr,
    output logic      pend
);

    // Update the pending flag by priority
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend <= 1'b0;
        else if (wr && inhibit_bit)  pend <= 1'b0;
        else if (set_req && irq_en)  pend <= 1'b1;
        else if (rd_clr)             pend <= 1'b0;
    end

    // R3
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(irq_en));

    // R5
    irq_four_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(mode) == SEQ_FOUR);

    // R7
    inhibit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && inhibit_bit) |=> !pend);

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_req) |=> !pend);

endmodule

// File: rtl/frame_seq_ctrl.sv
// Frame sequencer controller top: counts CPU cycles and issues registered
// quarter and half frame strobes and the frame interrupt flag. Assumes
// ctl_wr and stat_rd are single-cycle pulses in the CPU clock domain.
module frame_seq_ctrl
    import frame_seq_pkg::*;
#(
    parameter int unsigned STEP1 = 7457,
    parameter int unsigned STEP2 = 14913,
    parameter int unsigned STEP3 = 22371,
    parameter int unsigned STEP4 = 29829,
    parameter int unsigned STEP5 = 37281
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_mode_bit,
    input  logic ctl_irq_inhibit_bit,
    input  logic stat_rd,
    output logic qtr_stb,
    output logic half_stb,
    output logic irq_pend
);

    localparam int unsigned STEPS [NSTEP] = '{STEP1, STEP2, STEP3, STEP4, STEP5};

    seq_mode_e        mode;
    logic             irq_en;
    logic             odd;
    logic [NSTEP-1:0] hit;
    step_evt_t        evt;

    fseq_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctl_wr),
        .mode_bit    (ctl_mode_bit),
        .inhibit_bit (ctl_irq_inhibit_bit),
        .mode        (mode),
        .irq_en      (irq_en),
        .odd         (odd)
    );

    fseq_timer #(.STEP_AT(STEPS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .odd   (odd),
        .mode  (mode),
        .hit   (hit)
    );

    fseq_decode u_dec (
        .hit         (hit),
        .mode        (mode),
        .wr          (ctl_wr),
        .wr_mode_bit (ctl_mode_bit),
        .evt         (evt)
    );

    fseq_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (evt.irq_step),
        .irq_en      (irq_en),
        .mode        (mode),
        .wr          (ctl_wr),
        .inhibit_bit (ctl_irq_inhibit_bit),
        .rd_clr      (stat_rd),
        .pend        (irq_pend)
    );

    // Register the strobes so each is one clean cycle wide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qtr_stb  <= 1'b0;
            half_stb <= 1'b0;
        end else begin
            qtr_stb  <= evt.qtr;
            half_stb <= evt.half;
        end
    end

    // R2 R4
    half_with_qtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_stb |-> qtr_stb);

    // R8
    five_write_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_mode_bit) |=> (qtr_stb && half_stb));

    // R8
    four_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_mode_bit) |=> (!qtr_stb && !half_stb));

endmodule

// File: tb/frame_seq_ctrl_bench.sv
// Directed bench: every cycle is compared against a model of the requirements.
module frame_seq_ctrl_bench;

    localparam int S1 = 10, S2 = 20, S3 = 30, S4 = 40, S5 = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0, ctl_mode_bit = 1'b0, ctl_irq_inhibit_bit = 1'b0, stat_rd = 1'b0;
    logic qtr_stb, half_stb, irq_pend;

    int checks = 0;
    int fails = 0;

    // reference state
    int   ref_pos = 0;
    bit   ref_odd = 1'b0;
    bit   ref_five = 1'b0;
    bit   ref_ien = 1'b0;
    bit   ref_irq = 1'b0;
    bit   exp_q = 1'b0, exp_h = 1'b0;

    always #2.5 clk = ~clk;

    frame_seq_ctrl #(.STEP1(S1), .STEP2(S2), .STEP3(S3), .STEP4(S4), .STEP5(S5)) u_frame_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode_bit(ctl_mode_bit),
        .ctl_irq_inhibit_bit(ctl_irq_inhibit_bit), .stat_rd(stat_rd),
        .qtr_stb(qtr_stb), .half_stb(half_stb), .irq_pend(irq_pend)
    );

    task automatic check(input string tag, input string what, input logic got, input bit exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %b expected %b (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare at next negedge
    task automatic tick(input string tag, input bit wr, input bit mbit, input bit ibit, input bit rd);
        bit st;
        ctl_wr = wr; ctl_mode_bit = mbit; ctl_irq_inhibit_bit = ibit; stat_rd = rd;
        @(posedge clk);
        exp_q = 1'b0; exp_h = 1'b0; st = 1'b0;
        if (wr) begin
            exp_q = mbit; exp_h = mbit;
            ref_five = mbit; ref_ien = !ibit;
            if (ibit) ref_irq = 1'b0;
            else if (rd) ref_irq = 1'b0;
            ref_pos = ref_odd ? 2 : 1;
        end else begin
            if (ref_pos == S1 || ref_pos == S2 || ref_pos == S3 || ref_pos == S4) exp_q = 1'b1;
            if (!ref_five) begin
                exp_h = (ref_pos == S2 || ref_pos == S4);
                st = (ref_pos == S4);
            end else begin
                exp_h = (ref_pos == S1 || ref_pos == S3);
            end
            if (st && ref_ien) ref_irq = 1'b1;
            else if (rd) ref_irq = 1'b0;
            if ((!ref_five && ref_pos == S4) || (ref_five && ref_pos == S5)) ref_pos = 0;
            else ref_pos++;
        end
        ref_odd = !ref_odd;
        @(negedge clk);
        ctl_wr = 1'b0; stat_rd = 1'b0;
        check(tag, "qtr_stb", qtr_stb, exp_q);
        check(tag, "half_stb", half_stb, exp_h);
        check(tag, "irq_pend", irq_pend, ref_irq);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // R1: reset state and first frame with interrupt disabled
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "qtr_stb", qtr_stb, 1'b0);
        check("R1", "half_stb", half_stb, 1'b0);
        check("R1", "irq_pend", irq_pend, 1'b0);
        rst_n = 1'b1;
        ref_pos = 0; ref_odd = 1'b0; ref_five = 1'b0; ref_ien = 1'b0; ref_irq = 1'b0;
        idle("R1", S1 + 1);
        idle("R3", S4 + 5);   // step 4 passes with interrupt disabled
    endtask

    // R2 R3: four-step with interrupt enabled, even-cycle write
    task automatic t_four_enabled();
        if (ref_odd) idle("R9", 1);
        tick("R6", 1'b1, 1'b0, 1'b0, 1'b0);
        idle("R2", 2 * (S4 + 1) + 3);
        check("R3", "irq_pend", irq_pend, 1'b1);
    endtask

    // R10: status read clears; read colliding with step 4 loses
    task automatic t_read();
        tick("R10", 1'b0, 1'b0, 1'b0, 1'b1);
        check("R10", "irq_pend", irq_pend, 1'b0);
        while (ref_pos != S4) tick("R10", 1'b0, 1'b0, 1'b0, 1'b0);
        tick("R10", 1'b0, 1'b0, 1'b0, 1'b1);
        check("R10", "irq_pend", irq_pend, 1'b1);
    endtask

    // R7: write without inhibit keeps flag, with inhibit clears it
    task automatic t_inhibit();
        tick("R7", 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7", "irq_pend", irq_pend, 1'b1);
        idle("R7", 3);
        tick("R7", 1'b1, 1'b0, 1'b1, 1'b0);
        check("R7", "irq_pend", irq_pend, 1'b0);
        idle("R3", S4 + 3);
    endtask

    // R4 R5 R8: five-step writes fire at once, no interrupt ever
    task automatic t_five();
        tick("R8", 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8", "half_stb", half_stb, 1'b1);
        idle("R4", 2 * (S5 + 1) + 4);
        check("R5", "irq_pend", irq_pend, 1'b0);
    endtask

    // R9: odd-cycle alignment in both modes
    task automatic t_odd_align();
        if (!ref_odd) idle("R9", 1);
        tick("R9", 1'b1, 1'b0, 1'b0, 1'b0);
        idle("R9", S1 + 2);
        if (ref_odd) idle("R9", 1);
        tick("R9", 1'b1, 1'b0, 1'b0, 1'b0);
        idle("R9", S1 + 2);
        if (!ref_odd) idle("R9", 1);
        tick("R9", 1'b1, 1'b1, 1'b1, 1'b0);
        idle("R11", S5 + 4);
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_four_enabled();
        t_read();
        t_inhibit();
        t_five();
        t_odd_align();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule